// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Controller

This block is the card-side control logic for a legacy-bus plug-and-play configuration scheme. The host first writes a register index through an index strobe. It then moves data through a write-data strobe and a read-data strobe. The card keeps track of its own configuration state: waiting for the initiation key, sleep, isolation or config. It also holds its card select number (CSN) and its selected logical device, and it remembers the host's read-port address.

Card-level command registers are decoded here:
- The self-clearing control register is one such command register.
- The wake command compares the written byte with the stored CSN. A zero byte sends a matching sleeping card to isolation, and any other byte sends it to config.
- The CSN register, when written during isolation, assigns a CSN and moves the card to config.

Resource bytes stream out of a small internal ROM. A status ready flag models the fetch latency of that ROM.

The initiation-key detector sits outside the block and is represented by one `key_seen` input. The block signals each identifier-bit compare request made during isolation with a one-cycle pulse. The serial arbitration itself is not part of the block.

Top module: `pnp_card_ctl`

## Requirements
- R1: During and after a synchronous reset, the outputs take these values: `card_state` = 0, `csn` = 0, `ldn_sel` = 0, `rd_port_addr` = 0, `rd_data` = 0, `ld_reset` = 0 and `iso_bit_req` = 0. The state encoding on `card_state` is 0 = wait-for-key, 1 = sleep, 2 = isolation, 3 = config.
- R2: A `key_seen` pulse moves the card from wait-for-key (0) to sleep (1). While the card is in wait-for-key, index writes and data writes have no effect. Reads in that state return 0x00.
- R3: A data write to index 0x00 sets `rd_port_addr` to {written byte, 2'b00}. A read of index 0x00 returns 0x00.
- R4: Index 0x02 is the control register. Its effects appear one cycle after the write cycle:
  - bit 2 clears `csn` to 0;
  - bit 1 returns the card to wait-for-key and keeps `csn`;
  - bit 0 pulses `ld_reset` and changes neither `csn` nor the state.
- R5: The control bits clear themselves. After one control write, `ld_reset` is high for exactly one cycle, starting in the cycle after the write.
- R6: A wake write (index 0x03) to a sleeping card whose `csn` equals the written byte moves the card to isolation if the byte is 0x00, and to config otherwise. A sleeping card whose `csn` does not match stays in sleep.
- R7: A wake write whose byte differs from `csn` moves a card in isolation or config to sleep.
- R8: A wake write whose byte equals `csn` rewinds the resource pointer. This applies in every state except wait-for-key. The next resource byte read is then byte 0.
- R9: In config, a read of index 0x04 with the card ready returns resource byte k and advances the pointer. Byte k is (k*RSTEP + ROFS) mod 256. The pointer wraps from ROM_DEPTH-1 to 0.
- R10: Bit 0 of index 0x05 is the ready flag; the other bits read 0. Ready reads 0 in the cycle right after a resource byte is consumed, and 1 from the cycle after that. A read of index 0x04 while ready is 0 returns 0x00 and does not advance the pointer.
- R11: A data write to index 0x06 during isolation stores the byte as `csn` and moves the card to config. A read of index 0x06 returns `csn`.
- R12: With NUM_LDN = 1, index 0x07 reads 0x00, writes to it are ignored, and `ldn_sel` stays 0. With NUM_LDN > 1, a config-state write of a value below NUM_LDN selects that device. A write of a value at or above NUM_LDN is ignored.
- R13: A read of index 0x01 during isolation gives a one-cycle `iso_bit_req` pulse in the following cycle. The same read in any other state gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_seen | input | 1 | Pulse from the external initiation-key detector |
| idx_we | input | 1 | Index write strobe; `host_din` becomes the register index |
| wr_we | input | 1 | Data write strobe to the indexed register |
| rd_re | input | 1 | Data read strobe from the indexed register |
| host_din | input | 8 | Host write byte for index and data writes |
| rd_data | output | 8 | Registered read result, valid the cycle after `rd_re` |
| card_state | output | 2 | Card state: 0 wait-for-key, 1 sleep, 2 isolation, 3 config |
| csn | output | 8 | Card select number |
| ldn_sel | output | 8 | Selected logical device number |
| rd_port_addr | output | 10 | Host read-port address |
| ld_reset | output | 1 | One-cycle reset pulse to the logical devices |
| iso_bit_req | output | 1 | One-cycle request to compare one identifier bit |

## Verification
Each kind of state fault shows at the ports, most of them within one or two cycles:
- A wrong configuration state shows at once on `card_state`. It also changes how the next wake or CSN write acts.
- A stale resource pointer shows in the next resource byte read, which is checked against the arithmetic ROM formula across a full wrap of the pointer.
- A ready flag that never drops, or never rises, shows in the status read and the data read issued right after a consume.
- A control bit that does not clear itself shows as an `ld_reset` pulse longer than one cycle.

// File: rtl/pnp_pkg.sv
package pnp_pkg;

  typedef enum logic [1:0] {
    ST_WFK   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_ISO   = 2'd2,
    ST_CFG   = 2'd3
  } card_st_e;

  localparam logic [7:0] IDX_RPORT = 8'h00;
  localparam logic [7:0] IDX_ISO   = 8'h01;
  localparam logic [7:0] IDX_CTL   = 8'h02;
  localparam logic [7:0] IDX_WAKE  = 8'h03;
  localparam logic [7:0] IDX_RSRC  = 8'h04;
  localparam logic [7:0] IDX_STAT  = 8'h05;
  localparam logic [7:0] IDX_CSN   = 8'h06;
  localparam logic [7:0] IDX_LDN   = 8'h07;

endpackage

// File: rtl/pnp_cmd_decode.sv
module pnp_cmd_decode
  import pnp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_wfk,
  input  logic       idx_we,
  input  logic       wr_we,
  input  logic [7:0] din,
  output logic [7:0] idx_q,
  output logic       wake_wr,
  output logic       csn_wr,
  output logic       ldn_wr,
  output logic [2:0] cfg_q,
  output logic [9:0] rport_q
);

  logic wr_ok;
  assign wr_ok   = wr_we && !in_wfk;
  assign wake_wr = wr_ok && (idx_q == IDX_WAKE);
  assign csn_wr  = wr_ok && (idx_q == IDX_CSN);
  assign ldn_wr  = wr_ok && (idx_q == IDX_LDN);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      cfg_q   <= '0;
      rport_q <= '0;
    end else begin
      if (idx_we && !in_wfk) idx_q <= din;
      // control bits live for one cycle only
      cfg_q <= (wr_ok && idx_q == IDX_CTL) ? din[2:0] : 3'b000;
      if (wr_ok && idx_q == IDX_RPORT) rport_q <= {din, 2'b00};
    end
  end

endmodule

// File: rtl/pnp_card_state.sv
module pnp_card_state
  import pnp_pkg::*;
#(
  parameter int NUM_LDN = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_seen,
  input  logic       wake_wr,
  input  logic       csn_wr,
  input  logic       ldn_wr,
  input  logic [2:0] cfg_q,
  input  logic [7:0] din,
  output card_st_e   st_q,
  output logic [7:0] csn_q,
  output logic [7:0] ldn_q,
  output logic       wake_hit
);

  logic csn_eq;
  assign csn_eq   = (din == csn_q);
  assign wake_hit = wake_wr && csn_eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_WFK;
    end else if (cfg_q[1]) begin
      st_q <= ST_WFK;
    end else begin
      unique case (st_q)
        ST_WFK:   if (key_seen) st_q <= ST_SLEEP;
        ST_SLEEP: if (wake_hit) st_q <= (din == 8'h00) ? ST_ISO : ST_CFG;
        ST_ISO: begin
          if (wake_wr && !csn_eq) st_q <= ST_SLEEP;
          else if (csn_wr)        st_q <= ST_CFG;
        end
        ST_CFG:   if (wake_wr && !csn_eq) st_q <= ST_SLEEP;
        default:  st_q <= ST_WFK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                      csn_q <= '0;
    else if (cfg_q[2])                            csn_q <= '0;
    else if (csn_wr && (st_q == ST_ISO || st_q == ST_CFG)) csn_q <= din;
  end

  generate
    if (NUM_LDN > 1) begin : g_multi_ldn
      localparam logic [7:0] LDN_LIM = 8'(NUM_LDN);
      always_ff @(posedge clk) begin
        if (rst) ldn_q <= '0;
        else if (ldn_wr && st_q == ST_CFG && din < LDN_LIM) ldn_q <= din;
      end
    end else begin : g_single_ldn
      assign ldn_q = 8'h00;
    end
  endgenerate

endmodule

// File: rtl/pnp_rsrc_stream.sv
module pnp_rsrc_stream #(
  parameter int ROM_DEPTH = 16,
  parameter int RSTEP     = 37,
  parameter int ROFS      = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       consume,
  input  logic       rewind,
  output logic [7:0] byte_q,
  output logic       ready_q
);

  localparam int PTR_W = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ROM_DEPTH - 1);

  logic [7:0]       rom_mem [ROM_DEPTH];
  logic [PTR_W-1:0] ptr_q;

  initial begin
    for (int i = 0; i < ROM_DEPTH; i++) rom_mem[i] = 8'((i * RSTEP + ROFS) % 256);
  end

  // synchronous read port, block-RAM friendly
  always_ff @(posedge clk) begin
    byte_q <= rom_mem[ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      ready_q <= 1'b0;
    end else if (rewind) begin
      ptr_q   <= '0;
      ready_q <= 1'b0;
    end else if (consume) begin
      ptr_q   <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
    end
  end

endmodule

// File: rtl/pnp_card_ctl.sv
module pnp_card_ctl
  import pnp_pkg::*;
#(
  parameter int NUM_LDN   = 1,
  parameter int ROM_DEPTH = 16,
  parameter int RSTEP     = 37,
  parameter int ROFS      = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_seen,
  input  logic       idx_we,
  input  logic       wr_we,
  input  logic       rd_re,
  input  logic [7:0] host_din,
  output logic [7:0] rd_data,
  output logic [1:0] card_state,
  output logic [7:0] csn,
  output logic [7:0] ldn_sel,
  output logic [9:0] rd_port_addr,
  output logic       ld_reset,
  output logic       iso_bit_req
);

  card_st_e   st_q;
  logic [7:0] idx_q;
  logic       wake_wr, csn_wr, ldn_wr, wake_hit;
  logic [2:0] cfg_q;
  logic [7:0] rom_byte;
  logic       rsrc_ready;
  logic       consume;

  pnp_cmd_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .in_wfk  (st_q == ST_WFK),
    .idx_we  (idx_we),
    .wr_we   (wr_we),
    .din     (host_din),
    .idx_q   (idx_q),
    .wake_wr (wake_wr),
    .csn_wr  (csn_wr),
    .ldn_wr  (ldn_wr),
    .cfg_q   (cfg_q),
    .rport_q (rd_port_addr)
  );

  pnp_card_state #(.NUM_LDN(NUM_LDN)) u_st (
    .clk      (clk),
    .rst      (rst),
    .key_seen (key_seen),
    .wake_wr  (wake_wr),
    .csn_wr   (csn_wr),
    .ldn_wr   (ldn_wr),
    .cfg_q    (cfg_q),
    .din      (host_din),
    .st_q     (st_q),
    .csn_q    (csn),
    .ldn_q    (ldn_sel),
    .wake_hit (wake_hit)
  );

  assign consume = rd_re && (idx_q == IDX_RSRC) && (st_q == ST_CFG) && rsrc_ready;

  pnp_rsrc_stream #(.ROM_DEPTH(ROM_DEPTH), .RSTEP(RSTEP), .ROFS(ROFS)) u_rsrc (
    .clk     (clk),
    .rst     (rst),
    .consume (consume),
    .rewind  (wake_hit),
    .byte_q  (rom_byte),
    .ready_q (rsrc_ready)
  );

  assign card_state = st_q;
  assign ld_reset   = cfg_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= '0;
      iso_bit_req <= 1'b0;
    end else begin
      iso_bit_req <= rd_re && (idx_q == IDX_ISO) && (st_q == ST_ISO);
      if (rd_re) begin
        if (st_q == ST_WFK) begin
          rd_data <= '0;
        end else begin
          unique case (idx_q)
            IDX_RSRC: rd_data <= consume ? rom_byte : 8'h00;
            IDX_STAT: rd_data <= (st_q == ST_CFG) ? {7'b0, rsrc_ready} : 8'h00;
            IDX_CSN:  rd_data <= csn;
            IDX_LDN:  rd_data <= ldn_sel;
            default:  rd_data <= 8'h00;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/pnp_card_ctl_chk.sv
module pnp_card_ctl_chk #(
  parameter int NUM_LDN = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       key_seen,
  input logic       wr_we,
  input logic       rd_re,
  input logic [7:0] idx_q,
  input logic [1:0] card_state,
  input logic [7:0] csn,
  input logic [7:0] ldn_sel,
  input logic [2:0] cfg_q,
  input logic       ready,
  input logic       ld_reset,
  input logic       iso_bit_req
);

  a_r2_wfk_hold: assert property (@(posedge clk) disable iff (rst)
    (card_state == 2'd0 && !key_seen) |=> card_state == 2'd0);

  a_r2_key_to_sleep: assert property (@(posedge clk) disable iff (rst)
    (card_state == 2'd0 && key_seen && !cfg_q[1]) |=> card_state == 2'd1);

  a_r4_csn_clear: assert property (@(posedge clk) disable iff (rst)
    cfg_q[2] |=> csn == 8'h00);

  a_r4_back_to_wfk: assert property (@(posedge clk) disable iff (rst)
    cfg_q[1] |=> card_state == 2'd0);

  a_r5_ldrst_single: assert property (@(posedge clk) disable iff (rst)
    (ld_reset && !(wr_we && idx_q == 8'h02)) |=> !ld_reset);

  a_r10_ready_drop: assert property (@(posedge clk) disable iff (rst)
    (rd_re && idx_q == 8'h04 && card_state == 2'd3 && ready) |=> !ready);

  a_r10_ready_rise: assert property (@(posedge clk) disable iff (rst)
    (!ready && !(wr_we && idx_q == 8'h03)) |=> ready);

  a_r13_iso_only: assert property (@(posedge clk) disable iff (rst)
    iso_bit_req |-> $past(card_state) == 2'd2);

  generate
    if (NUM_LDN == 1) begin : g_one
      a_r12_single_ldn: assert property (@(posedge clk) disable iff (rst)
        ldn_sel == 8'h00);
    end
  endgenerate

endmodule

bind pnp_card_ctl pnp_card_ctl_chk #(.NUM_LDN(NUM_LDN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .key_seen    (key_seen),
  .wr_we       (wr_we),
  .rd_re       (rd_re),
  .idx_q       (idx_q),
  .card_state  (card_state),
  .csn         (csn),
  .ldn_sel     (ldn_sel),
  .cfg_q       (cfg_q),
  .ready       (rsrc_ready),
  .ld_reset    (ld_reset),
  .iso_bit_req (iso_bit_req)
);

// File: tb/test_pnp_card_ctl.sv
`timescale 1ns/1ps
module test_pnp_card_ctl;

  localparam int DEPTH = 16;
  localparam int STEP  = 37;
  localparam int OFS   = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_seen = 1'b0, idx_we = 1'b0, wr_we = 1'b0, rd_re = 1'b0;
  logic [7:0] host_din = '0;
  logic [7:0] rd_data, csn, ldn_sel, rd_data_m, csn_m, ldn_sel_m;
  logic [1:0] card_state, card_state_m;
  logic [9:0] rd_port_addr, rd_port_addr_m;
  logic       ld_reset, iso_bit_req, ld_reset_m, iso_bit_req_m;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pnp_card_ctl #(.ROM_DEPTH(DEPTH), .RSTEP(STEP), .ROFS(OFS)) i_pnp_card_ctl (
    .clk(clk), .rst(rst), .key_seen(key_seen), .idx_we(idx_we), .wr_we(wr_we),
    .rd_re(rd_re), .host_din(host_din), .rd_data(rd_data), .card_state(card_state),
    .csn(csn), .ldn_sel(ldn_sel), .rd_port_addr(rd_port_addr),
    .ld_reset(ld_reset), .iso_bit_req(iso_bit_req));

  pnp_card_ctl #(.NUM_LDN(4), .ROM_DEPTH(DEPTH), .RSTEP(STEP), .ROFS(OFS)) i_pnp_card_ctl_multi (
    .clk(clk), .rst(rst), .key_seen(key_seen), .idx_we(idx_we), .wr_we(wr_we),
    .rd_re(rd_re), .host_din(host_din), .rd_data(rd_data_m), .card_state(card_state_m),
    .csn(csn_m), .ldn_sel(ldn_sel_m), .rd_port_addr(rd_port_addr_m),
    .ld_reset(ld_reset_m), .iso_bit_req(iso_bit_req_m));

  function automatic logic [7:0] rom_exp(int k);
    return 8'(((k % DEPTH) * STEP + OFS) % 256);
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_idx(logic [7:0] v);
    idx_we = 1'b1; host_din = v;
    tick();
    idx_we = 1'b0;
  endtask

  task automatic wr_dat(logic [7:0] v);
    wr_we = 1'b1; host_din = v;
    tick();
    wr_we = 1'b0;
  endtask

  task automatic rd_dat();
    rd_re = 1'b1;
    tick();
    rd_re = 1'b0;
  endtask

  // read with the current index and load a new index in the same cycle
  task automatic rd_and_idx(logic [7:0] v);
    rd_re = 1'b1; idx_we = 1'b1; host_din = v;
    tick();
    rd_re = 1'b0; idx_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (2) tick();
    // R1 values held under reset
    check("R1 state", card_state, 0);
    check("R1 csn", csn, 0);
    check("R1 rd_data", rd_data, 0);
    rst = 1'b0;
    tick();
    check("R1 state", card_state, 0);
    check("R1 ldn", ldn_sel, 0);
    check("R1 rport", rd_port_addr, 0);
    check("R1 ld_reset", ld_reset, 0);
    check("R1 iso_bit_req", iso_bit_req, 0);

    // R2 writes ignored in wait-for-key
    wr_idx(8'h06); wr_dat(8'h05);
    check("R2 csn ignored", csn, 0);
    wr_idx(8'h00); wr_dat(8'h12);
    check("R2 rport ignored", rd_port_addr, 0);
    rd_dat();
    check("R2 read zero", rd_data, 0);
    key_seen = 1'b1; tick(); key_seen = 1'b0;
    check("R2 to sleep", card_state, 1);

    // R3 read-port address
    wr_idx(8'h00); wr_dat(8'h9C);
    check("R3 rport", rd_port_addr, 10'h270);
    rd_dat();
    check("R3 read zero", rd_data, 0);

    // R6 wake in sleep
    wr_idx(8'h03); wr_dat(8'h07);
    check("R6 nonmatch stays", card_state, 1);
    wr_dat(8'h00);
    check("R6 zero to iso", card_state, 2);

    // R13 compare pulse
    wr_idx(8'h01); rd_dat();
    check("R13 pulse", iso_bit_req, 1);
    tick();
    check("R13 pulse ends", iso_bit_req, 0);

    // R11 CSN assign
    wr_idx(8'h06); wr_dat(8'h2A);
    check("R11 state cfg", card_state, 3);
    check("R11 csn", csn, 8'h2A);
    rd_dat();
    check("R11 read csn", rd_data, 8'h2A);

    // R9 sweep beyond wrap, R10 not-ready read
    wr_idx(8'h04);
    for (int k = 0; k < DEPTH + 3; k++) begin
      rd_dat();
      check("R9 byte", rd_data, rom_exp(k));
      rd_dat();
      check("R10 not ready read", rd_data, 0);
    end
    // R10 status right after consume then later
    rd_and_idx(8'h05);
    check("R9 byte", rd_data, rom_exp(DEPTH + 3));
    rd_dat();
    check("R10 status low", rd_data, 0);
    rd_dat();
    check("R10 status high", rd_data, 1);

    // R8 matching wake rewinds
    wr_idx(8'h03); wr_dat(8'h2A);
    check("R8 stays cfg", card_state, 3);
    wr_idx(8'h04); rd_dat();
    check("R8 rewound", rd_data, rom_exp(0));

    // R7 nonmatching wake, then R6 nonzero
    wr_idx(8'h03); wr_dat(8'h11);
    check("R7 to sleep", card_state, 1);
    wr_dat(8'h2A);
    check("R6 nonzero to cfg", card_state, 3);

    // R12 logical device select
    wr_idx(8'h07); wr_dat(8'h03);
    check("R12 single ldn", ldn_sel, 0);
    check("R12 multi ldn", ldn_sel_m, 3);
    rd_dat();
    check("R12 single read", rd_data, 0);
    check("R12 multi read", rd_data_m, 3);
    wr_dat(8'h09);
    check("R12 multi out of range", ldn_sel_m, 3);

    // R4/R5 control register
    wr_idx(8'h02); wr_dat(8'h01);
    check("R5 pulse on", ld_reset, 1);
    tick();
    check("R5 pulse off", ld_reset, 0);
    check("R4 bit0 csn kept", csn, 8'h2A);
    check("R4 bit0 state kept", card_state, 3);
    wr_dat(8'h04); tick();
    check("R4 csn cleared", csn, 0);
    check("R4 bit2 state kept", card_state, 3);
    wr_idx(8'h06); wr_dat(8'h33);
    wr_idx(8'h02); wr_dat(8'h02); tick();
    check("R4 to wfk", card_state, 0);
    check("R4 csn kept", csn, 8'h33);
    check("R5 no pulse", ld_reset, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule